// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Register File

This block holds the configuration-space registers of a message-signalled interrupt capability. System software reaches it through a simple configuration port that carries a byte address, four byte enables and 32-bit data. Reads return data one cycle after the request. The block keeps the control word, the target address of the message, the 16-bit message payload and, when per-vector masking is built in, a mask register and a pending register.

Two static parameters choose the layout: `ADDR64` adds an upper address register, and `PV_MASK` adds the mask and pending registers. A third parameter, `VEC_LOG2`, advertises how many vectors the function supports. Software may ask for more vectors than that. The block tolerates the request and, once interrupts are enabled, cuts the stored request back to the advertised value.

The decoded enable, the granted vector count, the full message address, the payload and the mask go to a message generator. That generator sets and clears pending bits through a dedicated side port.

Top module: `msi_cap_regs`

## Requirements
- R1: The dwords of the structure sit at fixed offsets from `CAP_BASE`. Control is in the upper half of +0 and the low address is at +4. With `ADDR64`=1, the high address is at +8, data at +0x0C, mask at +0x10 and pending at +0x14. With `ADDR64`=0, data is at +8, mask at +0x0C and pending at +0x10. Any other address, and bytes +0/+1, read zero. `cfg_rvalid` and `cfg_rdata` follow `cfg_rd` by exactly one cycle.
- R2: The control word reads as follows: bit 0 enable, bits 3:1 the advertised log2 vector count (`VEC_LOG2`), bits 6:4 the requested log2 vector count, bit 7 equal to `ADDR64`, bit 8 equal to `PV_MASK`, and all other bits zero.
- R3: Of the control word, only the enable bit and bits 6:4 change on a write. The other bits keep their fixed values.
- R4: Bits 1:0 of the low address are never stored and always read zero. In 64-bit mode all 32 bits of the high address are writable. `msi_addr` is {high, low}, and the high half is zero in 32-bit mode.
- R5: The message data register is 16 bits and fully writable. The upper half of its dword reads zero and ignores writes.
- R6: With masking built in, only mask bits 0 to 2^`VEC_LOG2`-1 are writable. Every higher bit stays zero.
- R7: After a write that overlaps the structure and leaves the enable bit set, a requested count larger than `VEC_LOG2` is replaced by `VEC_LOG2`.
- R8: While the enable bit is clear, an oversized requested count written to the control word is kept as written.
- R9: The config port cannot write the pending register. `gen_pend_set` sets bits and `gen_pend_clr` clears them, and bits at or above 2^`VEC_LOG2` never become set.
- R10: On an overlapping write that leaves the enable bit set, pending bits at or above 2^(granted count) are discarded.
- R11: A write changes only the bytes whose `cfg_be` bit is set.
- R12: Reset clears the enable bit, the requested count, both address registers, data, mask and pending.
- R13: A write that does not overlap the structure changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Byte address, dword aligned (bits 1:0 zero) |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after `cfg_rd` |
| cfg_rdata | output | 32 | Read data |
| gen_pend_set | input | 32 | Pending bits to set, from the message generator |
| gen_pend_clr | input | 32 | Pending bits to clear, from the message generator |
| msi_en | output | 1 | Message interrupts enabled |
| msi_vec_log2 | output | 3 | Granted log2 vector count |
| msi_addr | output | 64 | Message address |
| msi_data | output | 16 | Message payload |
| msi_mask | output | 32 | Per-vector mask |
| msi_pend | output | 32 | Pending vectors |

## Verification
The assertions run on every cycle and cover the following properties:
- the cap on the granted count after any overlapping write while enabled;
- the untouched enable bit when the control byte is not written;
- the zero low address bits;
- the mask and pending bits staying inside the supported vector range;
- the pending register staying still when neither the generator nor a trimming write acts on it;
- the one-cycle read latency.

Only the bench scenarios can show the layout itself. That covers the read value of each offset, the byte-enable merges, an oversized request surviving while disabled and then being cut back once enabled, the pending trim against a smaller grant, writes outside the window, and the reset values.

// File: rtl/msi_cap_pkg.sv
// Shared types and layout helpers for the message-signalled interrupt
// capability register file. Assumes the capability base is dword aligned.
package msi_cap_pkg;

    // Register selected by a dword address inside the structure
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_ADLO,
        SEL_ADHI,
        SEL_DATA,
        SEL_MASK,
        SEL_PEND
    } cap_sel_e;

    // Bit positions of the control word (software decodes them)
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_CAP_LSB = 1;
    localparam int CTL_REQ_LSB = 4;
    localparam int CTL_A64_BIT = 7;
    localparam int CTL_PVM_BIT = 8;

    // Structure size in bytes for the four layouts
    function automatic int cap_size_bytes(bit a64, bit pvm);
        if (pvm) return a64 ? 32'h18 : 32'h14;
        return a64 ? 32'h0E : 32'h0A;
    endfunction

    // Register held by relative dword index rel
    function automatic cap_sel_e sel_of_dword(logic [5:0] rel, bit a64, bit pvm);
        case (rel)
            6'd0:    return SEL_CTRL;
            6'd1:    return SEL_ADLO;
            6'd2:    return a64 ? SEL_ADHI : SEL_DATA;
            6'd3:    return a64 ? SEL_DATA : (pvm ? SEL_MASK : SEL_NONE);
            6'd4:    return a64 ? (pvm ? SEL_MASK : SEL_NONE) : (pvm ? SEL_PEND : SEL_NONE);
            6'd5:    return (a64 && pvm) ? SEL_PEND : SEL_NONE;
            default: return SEL_NONE;
        endcase
    endfunction

    // Mask with the lowest 2^lg bits set (lg up to 5)
    function automatic logic [31:0] low_vec_mask(logic [2:0] lg);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < (1 << lg)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/msi_cap_decode.sv
// Address decode: maps a config address onto one register of the
// structure and reports which enabled byte lanes fall inside it.
// Assumes CAP_BASE is dword aligned and the structure fits below 0x100.
module msi_cap_decode
    import msi_cap_pkg::*;
#(
    parameter logic [7:0] CAP_BASE = 8'h50,
    parameter bit         ADDR64   = 1'b1,
    parameter bit         PV_MASK  = 1'b1
) (
    input  logic [5:0] dw_addr,
    input  logic [3:0] be,
    output cap_sel_e   sel,
    output logic [3:0] lane_hit
);
    localparam logic [5:0] BASE_DW  = CAP_BASE[7:2];
    localparam int         CAP_SIZE = cap_size_bytes(ADDR64, PV_MASK);

    logic [5:0] rel;
    logic       in_front;

    // Relative dword index and whether the address is not below the base
    always_comb begin
        rel      = dw_addr - BASE_DW;
        in_front = (dw_addr >= BASE_DW);
    end

    // Register select and per-lane overlap with the structure's byte range
    always_comb begin
        logic [7:0] off;
        sel = in_front ? sel_of_dword(rel, ADDR64, PV_MASK) : SEL_NONE;
        for (int i = 0; i < 4; i++) begin
            off         = {rel, 2'(i)};
            lane_hit[i] = be[i] && in_front && (int'(off) < CAP_SIZE);
        end
    end

endmodule

// File: rtl/msi_cap_ctrl.sv
// Control word: enable bit and requested vector count, with the clamp
// of an oversized request once interrupts are enabled. Also exports the
// post-write values so the pending trim can use them in the same cycle.
module msi_cap_ctrl
    import msi_cap_pkg::*;
#(
    parameter int VEC_LOG2 = 3,
    parameter bit ADDR64   = 1'b1,
    parameter bit PV_MASK  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctl_byte,
    input  logic        wr_en_bit,
    input  logic [2:0]  wr_req,
    input  logic        wr_overlap,
    output logic        en,
    output logic [2:0]  req_log2,
    output logic        nxt_en,
    output logic [2:0]  nxt_req,
    output logic [15:0] ctrl_word
);
    localparam logic [2:0] CAP_LOG2 = 3'(VEC_LOG2);

    // Next enable and request, with the clamp applied after the merge
    always_comb begin
        nxt_en  = en;
        nxt_req = req_log2;
        if (wr_ctl_byte) begin
            nxt_en  = wr_en_bit;
            nxt_req = wr_req;
        end
        if (wr_overlap && nxt_en && (nxt_req > CAP_LOG2)) nxt_req = CAP_LOG2;
    end

    // Control state register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            req_log2 <= 3'd0;
        end else begin
            en       <= nxt_en;
            req_log2 <= nxt_req;
        end
    end

    // Read view of the control word
    always_comb begin
        ctrl_word                                 = '0;
        ctrl_word[CTL_EN_BIT]                     = en;
        ctrl_word[CTL_CAP_LSB +: 3]               = CAP_LOG2;
        ctrl_word[CTL_REQ_LSB +: 3]               = req_log2;
        ctrl_word[CTL_A64_BIT]                    = ADDR64;
        ctrl_word[CTL_PVM_BIT]                    = PV_MASK;
    end

    // R7: an overlapping write never leaves an enabled function over its capability
    a_r7_clamp_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_overlap |=> (!en || (req_log2 <= CAP_LOG2)));

    // R8: a disabling write stores the requested count unchanged
    a_r8_keep_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl_byte && !wr_en_bit) |=> (req_log2 == $past(wr_req)));

    // R3: the enable bit moves only through its own byte
    a_r3_en_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctl_byte |=> $stable(en));

endmodule

// File: rtl/msi_cap_msg.sv
// Message address and payload registers. The high address register is
// generated only for the 64-bit layout; otherwise it reads as zero.
module msi_cap_msg #(
    parameter bit ADDR64 = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic        wr_data,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] addr_lo,
    output logic [31:0] addr_hi,
    output logic [15:0] data
);
    // Low address: byte merge with bits 1:0 forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo <= '0;
        end else if (wr_lo) begin
            for (int i = 0; i < 4; i++) begin
                if (be[i]) addr_lo[8*i +: 8] <= wdata[8*i +: 8];
            end
            addr_lo[1:0] <= 2'b00;
        end
    end

    // Payload: lower two byte lanes only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (wr_data) begin
            for (int i = 0; i < 2; i++) begin
                if (be[i]) data[8*i +: 8] <= wdata[8*i +: 8];
            end
        end
    end

    generate
        if (ADDR64) begin : g_hi
            // High address: fully writable byte merge
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_hi <= '0;
                end else if (wr_hi) begin
                    for (int i = 0; i < 4; i++) begin
                        if (be[i]) addr_hi[8*i +: 8] <= wdata[8*i +: 8];
                    end
                end
            end
        end else begin : g_no_hi
            assign addr_hi = '0;
        end
    endgenerate

    // R4: the stored low address stays dword aligned
    a_r4_lo_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        addr_lo[1:0] == 2'b00);

    // R5: the payload changes only on a write to its register
    a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(data));

endmodule

// File: rtl/msi_cap_vecmask.sv
// Per-vector mask and pending registers, generated only when masking is
// built in. Pending is driven by the message generator and trimmed to
// the granted vector count on an overlapping write while enabled.
module msi_cap_vecmask
    import msi_cap_pkg::*;
#(
    parameter bit PV_MASK  = 1'b1,
    parameter int VEC_LOG2 = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_mask,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic [31:0] gen_set,
    input  logic [31:0] gen_clr,
    input  logic        trim,
    input  logic [2:0]  trim_log2,
    output logic [31:0] mask,
    output logic [31:0] pend
);
    localparam logic [31:0] CAP_BITS = low_vec_mask(3'(VEC_LOG2));

    generate
        if (PV_MASK) begin : g_mask
            logic [31:0] alloc_bits;
            logic [31:0] pend_n;

            // Vectors inside the granted count
            always_comb alloc_bits = low_vec_mask(trim_log2);

            // Mask: byte merge limited to supported vectors
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mask <= '0;
                end else if (wr_mask) begin
                    for (int i = 0; i < 4; i++) begin
                        if (be[i]) mask[8*i +: 8] <= wdata[8*i +: 8] & CAP_BITS[8*i +: 8];
                    end
                end
            end

            // Next pending: generator update first, then the trim
            always_comb begin
                pend_n = ((pend | gen_set) & ~gen_clr) & CAP_BITS;
                if (trim) pend_n = pend_n & alloc_bits;
            end

            // Pending state register
            always_ff @(posedge clk) begin
                if (!rst_n) pend <= '0;
                else        pend <= pend_n;
            end

            // R6: no mask bit outside the supported vectors
            a_r6_mask_in_range: assert property (@(posedge clk) disable iff (!rst_n)
                (mask & ~CAP_BITS) == 32'h0);

            // R9: no pending bit outside the supported vectors
            a_r9_pend_in_range: assert property (@(posedge clk) disable iff (!rst_n)
                (pend & ~CAP_BITS) == 32'h0);

            // R9: pending is quiet without generator action or trim
            a_r9_pend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (gen_set == 32'h0 && gen_clr == 32'h0 && !trim) |=> $stable(pend));

            // R10: a trim leaves nothing above the granted count
            a_r10_trim_bound: assert property (@(posedge clk) disable iff (!rst_n)
                trim |=> ((pend & ~$past(alloc_bits)) == 32'h0));
        end else begin : g_no_mask
            assign mask = '0;
            assign pend = '0;
        end
    endgenerate

endmodule

// File: rtl/msi_cap_regs.sv
// Top of the capability register file: decodes the config port, drives
// write strobes into the register groups, muxes read data into a
// one-cycle read response and exports decoded state to the generator.
// Assumes dword-aligned config accesses (cfg_addr[1:0] zero).
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter logic [7:0] CAP_BASE = 8'h50,
    parameter bit         ADDR64   = 1'b1,
    parameter bit         PV_MASK  = 1'b1,
    parameter int         VEC_LOG2 = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cfg_rd,
    input  logic [7:0]  cfg_addr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic        cfg_rvalid,
    output logic [31:0] cfg_rdata,
    input  logic [31:0] gen_pend_set,
    input  logic [31:0] gen_pend_clr,
    output logic        msi_en,
    output logic [2:0]  msi_vec_log2,
    output logic [63:0] msi_addr,
    output logic [15:0] msi_data,
    output logic [31:0] msi_mask,
    output logic [31:0] msi_pend
);
    cap_sel_e    sel;
    logic [3:0]  lane_hit;
    logic        wr_overlap;
    logic        nxt_en;
    logic [2:0]  nxt_req;
    logic [15:0] ctrl_word;
    logic [31:0] addr_lo, addr_hi;
    logic [31:0] rd_mux;

    msi_cap_decode #(.CAP_BASE(CAP_BASE), .ADDR64(ADDR64), .PV_MASK(PV_MASK)) u_decode (
        .dw_addr  (cfg_addr[7:2]),
        .be       (cfg_be),
        .sel      (sel),
        .lane_hit (lane_hit)
    );

    // Any enabled write byte inside the structure
    always_comb wr_overlap = cfg_wr && (lane_hit != 4'b0000);

    msi_cap_ctrl #(.VEC_LOG2(VEC_LOG2), .ADDR64(ADDR64), .PV_MASK(PV_MASK)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctl_byte (cfg_wr && sel == SEL_CTRL && cfg_be[2]),
        .wr_en_bit   (cfg_wdata[16 + CTL_EN_BIT]),
        .wr_req      (cfg_wdata[16 + CTL_REQ_LSB +: 3]),
        .wr_overlap  (wr_overlap),
        .en          (msi_en),
        .req_log2    (msi_vec_log2),
        .nxt_en      (nxt_en),
        .nxt_req     (nxt_req),
        .ctrl_word   (ctrl_word)
    );

    msi_cap_msg #(.ADDR64(ADDR64)) u_msg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (cfg_wr && sel == SEL_ADLO),
        .wr_hi   (cfg_wr && sel == SEL_ADHI),
        .wr_data (cfg_wr && sel == SEL_DATA && cfg_be[1:0] != 2'b00),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .addr_lo (addr_lo),
        .addr_hi (addr_hi),
        .data    (msi_data)
    );

    msi_cap_vecmask #(.PV_MASK(PV_MASK), .VEC_LOG2(VEC_LOG2)) u_vecmask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask   (cfg_wr && sel == SEL_MASK),
        .be        (cfg_be),
        .wdata     (cfg_wdata),
        .gen_set   (gen_pend_set),
        .gen_clr   (gen_pend_clr),
        .trim      (wr_overlap && nxt_en),
        .trim_log2 (nxt_req),
        .mask      (msi_mask),
        .pend      (msi_pend)
    );

    // Message address view for the generator
    always_comb msi_addr = {addr_hi, addr_lo};

    // Read data selection by register
    always_comb begin
        case (sel)
            SEL_CTRL: rd_mux = {ctrl_word, 16'h0000};
            SEL_ADLO: rd_mux = addr_lo;
            SEL_ADHI: rd_mux = addr_hi;
            SEL_DATA: rd_mux = {16'h0000, msi_data};
            SEL_MASK: rd_mux = msi_mask;
            SEL_PEND: rd_mux = msi_pend;
            default:  rd_mux = 32'h0;
        endcase
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= cfg_rd;
            if (cfg_rd) cfg_rdata <= rd_mux;
        end
    end

    // R1: a read request is answered on the following cycle
    a_r1_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |=> cfg_rvalid);

    // R1: accesses are dword aligned
    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr || cfg_rd) |-> (cfg_addr[1:0] == 2'b00));

endmodule

// File: tb/test_msi_cap_regs.sv
`timescale 1ns/1ps
module test_msi_cap_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic [31:0] gen_pend_set = '0;
    logic [31:0] gen_pend_clr = '0;
    logic        msi_en;
    logic [2:0]  msi_vec_log2;
    logic [63:0] msi_addr;
    logic [15:0] msi_data;
    logic [31:0] msi_mask;
    logic [31:0] msi_pend;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    msi_cap_regs i_msi_cap_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
        .gen_pend_set(gen_pend_set), .gen_pend_clr(gen_pend_clr),
        .msi_en(msi_en), .msi_vec_log2(msi_vec_log2), .msi_addr(msi_addr),
        .msi_data(msi_data), .msi_mask(msi_mask), .msi_pend(msi_pend)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: issue a read and queue the expected response
    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        q_exp.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic gen(logic [31:0] s, logic [31:0] c);
        @(negedge clk);
        gen_pend_set = s; gen_pend_clr = c;
        @(negedge clk);
        gen_pend_set = '0; gen_pend_clr = '0;
    endtask

    // Monitor: compare each read response with the head of the queue
    always @(negedge clk) begin
        if (rst_n && cfg_rvalid) begin
            if (q_exp.size() == 0) begin
                chk("R1 unexpected read response", 64'(cfg_rdata), 64'hX);
            end else begin
                string t;
                logic [31:0] e;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                chk(t, 64'(cfg_rdata), 64'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 / R2 reset values; ctrl = cap 3, 64-bit, masking
        chk("R12 msi_en after reset", 64'(msi_en), 64'h0);
        chk("R12 msi_addr after reset", msi_addr, 64'h0);
        rd(8'h50, 32'h0186_0000, "R2 R12 control word after reset");
        rd(8'h54, 32'h0, "R12 addr lo reset");
        rd(8'h58, 32'h0, "R12 addr hi reset");
        rd(8'h5C, 32'h0, "R12 data reset");
        rd(8'h60, 32'h0, "R12 mask reset");
        rd(8'h64, 32'h0, "R12 pending reset");
        rd(8'h68, 32'h0, "R1 beyond structure reads zero");
        rd(8'h40, 32'h0, "R1 below base reads zero");
        // R8: request 5 with enable clear is kept
        wr(8'h50, 32'h0050_0000, 4'hF);
        rd(8'h50, 32'h01D6_0000, "R8 oversized kept while disabled");
        wr(8'h5C, 32'h0000_1234, 4'hF);
        rd(8'h50, 32'h01D6_0000, "R8 still kept after data write");
        // R7: enable with request 5 clamps to 3
        wr(8'h50, 32'h0051_0000, 4'hF);
        rd(8'h50, 32'h01B7_0000, "R7 clamp on enable");
        chk("R7 msi_vec_log2 clamped", 64'(msi_vec_log2), 64'h3);
        chk("R7 msi_en set", 64'(msi_en), 64'h1);
        // R3: all-ones write touches only writable bits
        wr(8'h50, 32'hFFFF_FFFF, 4'hF);
        rd(8'h50, 32'h01B7_0000, "R3 read-only control bits");
        // R11: control byte lane not enabled
        wr(8'h50, 32'h0020_0000, 4'h3);
        rd(8'h50, 32'h01B7_0000, "R11 control lane disabled");
        wr(8'h50, 32'h0021_0000, 4'hF);
        rd(8'h50, 32'h01A7_0000, "R2 request 2 enabled");
        // R4 address registers
        wr(8'h54, 32'hFFFF_FFFF, 4'hF);
        rd(8'h54, 32'hFFFF_FFFC, "R4 low address bits 1:0 zero");
        wr(8'h54, 32'h1234_5677, 4'h5);
        rd(8'h54, 32'hFF34_FF74, "R11 partial low address merge");
        wr(8'h58, 32'hDEAD_BEEF, 4'hF);
        rd(8'h58, 32'hDEAD_BEEF, "R4 high address writable");
        chk("R4 msi_addr", msi_addr, 64'hDEAD_BEEF_FF34_FF74);
        // R5 data
        wr(8'h5C, 32'hABCD_5A5A, 4'hF);
        rd(8'h5C, 32'h0000_5A5A, "R5 data 16 bits");
        chk("R5 msi_data", 64'(msi_data), 64'h5A5A);
        // R6 mask
        wr(8'h60, 32'hFFFF_FFFF, 4'hF);
        rd(8'h60, 32'h0000_00FF, "R6 mask limited to 8 vectors");
        chk("R6 msi_mask", 64'(msi_mask), 64'hFF);
        // R9 pending
        wr(8'h64, 32'hFFFF_FFFF, 4'hF);
        rd(8'h64, 32'h0, "R9 pending not writable");
        gen(32'hFFFF_FFFF, 32'h0);
        rd(8'h64, 32'h0000_00FF, "R9 generator set in range only");
        gen(32'h0, 32'h0000_0001);
        chk("R9 generator clear", 64'(msi_pend), 64'hFE);
        // R10 trim to granted 4 vectors
        wr(8'h5C, 32'h0000_5A5A, 4'hF);
        rd(8'h64, 32'h0000_000E, "R10 pending trimmed to grant");
        // R13 writes outside the structure
        wr(8'h50, 32'h0070_0000, 4'h4);
        wr(8'h68, 32'hFFFF_FFFF, 4'hF);
        wr(8'h4C, 32'hFFFF_FFFF, 4'hF);
        rd(8'h50, 32'h01F6_0000, "R13 control unchanged by outside write");
        rd(8'h5C, 32'h0000_5A5A, "R13 data unchanged");
        chk("R13 msi_pend unchanged", 64'(msi_pend), 64'h0E);
        chk("R13 msi_mask unchanged", 64'(msi_mask), 64'hFF);
        wr(8'h50, 32'h0071_0000, 4'hF);
        rd(8'h50, 32'h01B7_0000, "R7 clamp 7 to 3");
        // R12 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R12 msi_en cleared", 64'(msi_en), 64'h0);
        chk("R12 msi_vec_log2 cleared", 64'(msi_vec_log2), 64'h0);
        chk("R12 msi_addr cleared", msi_addr, 64'h0);
        chk("R12 msi_data cleared", 64'(msi_data), 64'h0);
        chk("R12 msi_mask cleared", 64'(msi_mask), 64'h0);
        chk("R12 msi_pend cleared", 64'(msi_pend), 64'h0);
        rd(8'h50, 32'h0186_0000, "R12 control after second reset");
        repeat (3) @(negedge clk);
        if (q_exp.size() != 0) chk("R1 missing read responses", 64'(q_exp.size()), 64'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule